// File: doc/BRIEF.md
# Host Port Tagged FIFO Decoder

This block sits between an asynchronous slave host bus and an on-chip processor. It turns host read and write strobes, qualified by a chip select, a DMA acknowledge and a three-bit address, into single accesses on two byte queues and three small registers. Host writes fill an inbound queue that the processor drains through a pop port. The processor fills an outbound queue through a push port, and host reads drain it.

Every queue entry holds a byte and a one-bit kind marker: 0 for an ordinary data byte, 1 for a stream command. Each FIFO read names the kind it expects. If the entry at the head is of the other kind, the host receives 8'hFF and the entry stays in place. A DMA acknowledge turns any strobe into a data-byte transfer, whatever the address or the chip select. Each strobe passes through a two-stage synchroniser and acts once, on its rising edge.

Top module: `hostPortDecoder`

## Requirements
- R1: After reset, hostRdData, ctrlOut and immOut are 8'h00. Both queues are empty, so cpuInEmpty=1 and cpuOutFull=0. All three event pulses are low.
- R2: A rising edge on hostRd or hostWr performs exactly one access, however long the strobe stays high. Results and pulses appear at the third rising clock edge after the strobe is first high at a clock edge.
- R3: With hostDmaAck=0 and hostSel=0, no strobe changes hostRdData, either queue, or the registers.
- R4: With hostSel=1 and address 3'b000, a write pushes {kind 0, hostWrData} into the inbound queue. A read pops a kind-0 entry from the outbound queue onto hostRdData.
- R5: With hostSel=1 and address 3'b001, a write pushes a kind-1 entry and a read pops a kind-1 entry.
- R6: Address 3'b010 reads statusIn. A write to it changes no register and no queue.
- R7: Address 3'b011 writes and reads back ctrlOut. Address 3'b100 writes and reads back immOut.
- R8: Addresses 3'b101, 3'b110 and 3'b111 have no effect in either direction. hostRdData, the registers and the queues keep their values.
- R9: With hostDmaAck=1, a write pushes a kind-0 entry and a read pops a kind-0 entry, for any hostSel and address.
- R10: If a FIFO read expects a kind that differs from the outbound head, hostRdData becomes 8'hFF and mismatchPulse is high for one cycle. The head entry is kept.
- R11: A write into a full inbound queue of 16 entries is dropped and raises overrunPulse for one cycle. The 16 stored entries come out in order.
- R12: A FIFO read of an empty outbound queue sets hostRdData to 8'hFF and raises underrunPulse for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| hostDmaAck | input | 1 | DMA acknowledge; forces a data-byte transfer |
| hostSel | input | 1 | Chip select, active high |
| hostAddr | input | 3 | Host register address |
| hostRd | input | 1 | Asynchronous read strobe, active high |
| hostWr | input | 1 | Asynchronous write strobe, active high |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Registered host read byte |
| statusIn | input | 8 | Status value returned at address 3'b010 |
| ctrlOut | output | 8 | Host control register |
| immOut | output | 8 | Immediate command register |
| cpuPush | input | 1 | Push into the outbound queue |
| cpuPushTag | input | 1 | Kind of the pushed entry (1 = command) |
| cpuPushData | input | 8 | Byte of the pushed entry |
| cpuOutFull | output | 1 | Outbound queue full |
| cpuPop | input | 1 | Pop from the inbound queue |
| cpuPopTag | output | 1 | Kind of the inbound head entry |
| cpuPopData | output | 8 | Byte of the inbound head entry |
| cpuInEmpty | output | 1 | Inbound queue empty |
| overrunPulse | output | 1 | One-cycle pulse: write dropped on a full queue |
| underrunPulse | output | 1 | One-cycle pulse: read of an empty queue |
| mismatchPulse | output | 1 | One-cycle pulse: access kind differs from the head |

## Verification
The assertions assume that the host holds hostAddr, hostSel, hostDmaAck and hostWrData steady while a strobe is high. They also assume that each strobe stays high for at least three clock cycles and that read and write are never raised together. Register and read-data changes are therefore traced back to a strobe that was still high one cycle earlier. The bench drives every access through one task. That task sets the qualifiers at a falling edge, holds the strobe for three or more cycles, and releases the qualifiers only after the strobe has dropped and the synchroniser has settled.

// File: rtl/hostPortPkg.sv
package hostPortPkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_DATA,
    OP_CMD,
    OP_STATUS,
    OP_CTRL,
    OP_IMM
  } hostOp_e;

  // one-cycle access request from control to datapath
  typedef struct packed {
    logic    rdGo;
    logic    wrGo;
    hostOp_e op;
  } hostStrobe_t;

  localparam logic TAG_DATA = 1'b0;
  localparam logic TAG_CMD  = 1'b1;
endpackage

// File: rtl/tagQueue.sv
module tagQueue #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 16   // power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              pop,
  output logic [WORD_W-1:0] headWord,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                 (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headWord = mem[rdPtr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[PTR_W-1:0]] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostDmaAck,
  input  logic              hostSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  output hostStrobe_t       strb
);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IMM    = ADDR_W'(4);

  logic [1:0] rawStrobe;
  logic [1:0] edgeSeen;
  assign rawStrobe = {hostWr, hostRd};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-1:0], rawStrobe[g]};
    end
    assign edgeSeen[g] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

  hostOp_e op;
  always_comb begin
    op = OP_NONE;
    if (hostDmaAck) op = OP_DATA;
    else if (hostSel) begin
      case (hostAddr)
        A_DATA:   op = OP_DATA;
        A_CMD:    op = OP_CMD;
        A_STATUS: op = OP_STATUS;
        A_CTRL:   op = OP_CTRL;
        A_IMM:    op = OP_IMM;
        default:  op = OP_NONE;
      endcase
    end
  end

  assign strb.rdGo = edgeSeen[0];
  assign strb.wrGo = edgeSeen[1] & ~edgeSeen[0];  // read wins a tie
  assign strb.op   = op;
endmodule

// File: rtl/hostPortPath.sv
module hostPortPath
  import hostPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] immOut,
  input  logic              cpuPush,
  input  logic              cpuPushTag,
  input  logic [DATA_W-1:0] cpuPushData,
  output logic              cpuOutFull,
  input  logic              cpuPop,
  output logic              cpuPopTag,
  output logic [DATA_W-1:0] cpuPopData,
  output logic              cpuInEmpty,
  output logic              overrunPulse,
  output logic              underrunPulse,
  output logic              mismatchPulse
);
  localparam int WORD_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] BAD_BYTE = {DATA_W{1'b1}};

  logic [WORD_W-1:0] outHead, inHead;
  logic outEmpty, inFull;
  logic fifoOp, wantTag, tagOk, outPop, inPush;

  assign fifoOp  = (strb.op == OP_DATA) || (strb.op == OP_CMD);
  assign wantTag = (strb.op == OP_CMD) ? TAG_CMD : TAG_DATA;
  assign tagOk   = (outHead[DATA_W] == wantTag);
  assign outPop  = strb.rdGo && fifoOp && !outEmpty && tagOk;
  assign inPush  = strb.wrGo && fifoOp;

  tagQueue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) outQ (
    .clk(clk), .rstN(rstN),
    .push(cpuPush), .pushWord({cpuPushTag, cpuPushData}),
    .pop(outPop), .headWord(outHead),
    .full(cpuOutFull), .empty(outEmpty)
  );

  tagQueue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) inQ (
    .clk(clk), .rstN(rstN),
    .push(inPush), .pushWord({wantTag, hostWrData}),
    .pop(cpuPop), .headWord(inHead),
    .full(inFull), .empty(cpuInEmpty)
  );

  assign cpuPopTag  = inHead[DATA_W];
  assign cpuPopData = inHead[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData    <= '0;
      ctrlOut       <= '0;
      immOut        <= '0;
      overrunPulse  <= 1'b0;
      underrunPulse <= 1'b0;
      mismatchPulse <= 1'b0;
    end else begin
      overrunPulse  <= 1'b0;
      underrunPulse <= 1'b0;
      mismatchPulse <= 1'b0;
      if (strb.rdGo) begin
        case (strb.op)
          OP_DATA, OP_CMD: begin
            if (outEmpty) begin
              hostRdData    <= BAD_BYTE;
              underrunPulse <= 1'b1;
            end else if (!tagOk) begin
              hostRdData    <= BAD_BYTE;
              mismatchPulse <= 1'b1;
            end else begin
              hostRdData <= outHead[DATA_W-1:0];
            end
          end
          OP_STATUS: hostRdData <= statusIn;
          OP_CTRL:   hostRdData <= ctrlOut;
          OP_IMM:    hostRdData <= immOut;
          default: ;
        endcase
      end
      if (strb.wrGo) begin
        case (strb.op)
          OP_DATA, OP_CMD: if (inFull) overrunPulse <= 1'b1;
          OP_CTRL: ctrlOut <= hostWrData;
          OP_IMM:  immOut  <= hostWrData;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostPortDecoder.sv
module hostPortDecoder
  import hostPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostDmaAck,
  input  logic              hostSel,
  input  logic [2:0]        hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] immOut,
  input  logic              cpuPush,
  input  logic              cpuPushTag,
  input  logic [DATA_W-1:0] cpuPushData,
  output logic              cpuOutFull,
  input  logic              cpuPop,
  output logic              cpuPopTag,
  output logic [DATA_W-1:0] cpuPopData,
  output logic              cpuInEmpty,
  output logic              overrunPulse,
  output logic              underrunPulse,
  output logic              mismatchPulse
);
  hostStrobe_t strb;

  hostPortCtrl #(.ADDR_W(3), .SYNC_STAGES(2)) ctrl (
    .clk(clk), .rstN(rstN),
    .hostDmaAck(hostDmaAck), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .strb(strb)
  );

  hostPortPath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWrData(hostWrData), .statusIn(statusIn), .hostRdData(hostRdData),
    .ctrlOut(ctrlOut), .immOut(immOut),
    .cpuPush(cpuPush), .cpuPushTag(cpuPushTag), .cpuPushData(cpuPushData),
    .cpuOutFull(cpuOutFull), .cpuPop(cpuPop), .cpuPopTag(cpuPopTag),
    .cpuPopData(cpuPopData), .cpuInEmpty(cpuInEmpty),
    .overrunPulse(overrunPulse), .underrunPulse(underrunPulse),
    .mismatchPulse(mismatchPulse)
  );
endmodule

// File: rtl/hostPortDecoderChk.sv
module hostPortDecoderChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRd,
  input logic              hostWr,
  input logic              hostDmaAck,
  input logic [DATA_W-1:0] hostRdData,
  input logic [DATA_W-1:0] ctrlOut,
  input logic [DATA_W-1:0] immOut,
  input logic              overrunPulse,
  input logic              underrunPulse,
  input logic              mismatchPulse
);
  localparam logic [DATA_W-1:0] BAD_BYTE = {DATA_W{1'b1}};

  a_r10_mismatch_bad_byte: assert property (@(posedge clk) disable iff (!rstN)
    mismatchPulse |-> hostRdData == BAD_BYTE);

  a_r12_underrun_bad_byte: assert property (@(posedge clk) disable iff (!rstN)
    underrunPulse |-> hostRdData == BAD_BYTE);

  a_r2_mismatch_single: assert property (@(posedge clk) disable iff (!rstN)
    mismatchPulse |=> !mismatchPulse);

  a_r11_overrun_single: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |=> !overrunPulse);

  a_r12_read_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(underrunPulse && mismatchPulse));

  a_r7_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlOut) |-> ($past(hostWr) && !$past(hostDmaAck)));

  a_r7_imm_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(immOut) |-> ($past(hostWr) && !$past(hostDmaAck)));

  a_r2_read_data_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hostRdData) |-> $past(hostRd));
endmodule

bind hostPortDecoder hostPortDecoderChk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
  .hostDmaAck(hostDmaAck), .hostRdData(hostRdData), .ctrlOut(ctrlOut),
  .immOut(immOut), .overrunPulse(overrunPulse),
  .underrunPulse(underrunPulse), .mismatchPulse(mismatchPulse)
);

// File: tb/hostPortDecoder_test.sv
`timescale 1ns/1ps
module hostPortDecoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostDmaAck = 0, hostSel = 0, hostRd = 0, hostWr = 0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0, statusIn = 8'hA5;
  logic [7:0] hostRdData, ctrlOut, immOut, cpuPopData;
  logic cpuPush = 0, cpuPushTag = 0, cpuPop = 0;
  logic [7:0] cpuPushData = '0;
  logic cpuOutFull, cpuPopTag, cpuInEmpty;
  logic overrunPulse, underrunPulse, mismatchPulse;

  int checks = 0;
  int failures = 0;
  logic [7:0] seenRd;
  logic seenOvr, seenUnd, seenMis;

  always #5 clk = ~clk;

  hostPortDecoder uut (
    .clk(clk), .rstN(rstN), .hostDmaAck(hostDmaAck), .hostSel(hostSel),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .statusIn(statusIn),
    .ctrlOut(ctrlOut), .immOut(immOut), .cpuPush(cpuPush),
    .cpuPushTag(cpuPushTag), .cpuPushData(cpuPushData),
    .cpuOutFull(cpuOutFull), .cpuPop(cpuPop), .cpuPopTag(cpuPopTag),
    .cpuPopData(cpuPopData), .cpuInEmpty(cpuInEmpty),
    .overrunPulse(overrunPulse), .underrunPulse(underrunPulse),
    .mismatchPulse(mismatchPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host access; outputs sampled where the third clock edge lands
  task automatic hostAccess(input bit isRd, input bit dack, input bit sel,
                            input logic [2:0] addr, input logic [7:0] wd,
                            input int hold);
    @(negedge clk);
    hostDmaAck = dack; hostSel = sel; hostAddr = addr; hostWrData = wd;
    if (isRd) hostRd = 1'b1; else hostWr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    seenRd = hostRdData; seenOvr = overrunPulse;
    seenUnd = underrunPulse; seenMis = mismatchPulse;
    repeat (hold) @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0;
    repeat (4) @(negedge clk);
    hostDmaAck = 1'b0; hostSel = 1'b0; hostAddr = '0;
  endtask

  task automatic cpuPushOne(input logic tag, input logic [7:0] d);
    @(negedge clk);
    cpuPush = 1'b1; cpuPushTag = tag; cpuPushData = d;
    @(negedge clk);
    cpuPush = 1'b0;
  endtask

  task automatic cpuPopCheck(input string req, input logic tag, input logic [7:0] d);
    @(negedge clk);
    check(req, {31'd0, cpuInEmpty}, 32'd0);
    check(req, {31'd0, cpuPopTag}, {31'd0, tag});
    check(req, {24'd0, cpuPopData}, {24'd0, d});
    cpuPop = 1'b1;
    @(negedge clk);
    cpuPop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", {24'd0, hostRdData}, 32'd0);
    check("R1 ctrl", {24'd0, ctrlOut}, 32'd0);
    check("R1 imm", {24'd0, immOut}, 32'd0);
    check("R1 inEmpty", {31'd0, cpuInEmpty}, 32'd1);
    check("R1 outFull", {31'd0, cpuOutFull}, 32'd0);
    check("R1 pulses", {29'd0, overrunPulse, underrunPulse, mismatchPulse}, 32'd0);

    // R4 / R5 host writes into inbound queue
    hostAccess(0, 0, 1, 3'b000, 8'h5A, 0);
    hostAccess(0, 0, 1, 3'b001, 8'h33, 0);
    cpuPopCheck("R4 data write", 1'b0, 8'h5A);
    cpuPopCheck("R5 cmd write", 1'b1, 8'h33);

    // R4 / R5 / R10 / R12 reads with kind checking
    cpuPushOne(1'b0, 8'h11);
    cpuPushOne(1'b1, 8'h22);
    cpuPushOne(1'b0, 8'h44);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R4 data read", {24'd0, seenRd}, 32'h11);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R10 data vs cmd byte", {24'd0, seenRd}, 32'hFF);
    check("R10 pulse", {31'd0, seenMis}, 32'd1);
    hostAccess(1, 0, 1, 3'b001, 8'h00, 0);
    check("R5 cmd read kept head", {24'd0, seenRd}, 32'h22);
    check("R10 no pulse on match", {31'd0, seenMis}, 32'd0);
    hostAccess(1, 0, 1, 3'b001, 8'h00, 0);
    check("R10 cmd vs data byte", {24'd0, seenRd}, 32'hFF);
    check("R10 pulse2", {31'd0, seenMis}, 32'd1);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R10 head kept", {24'd0, seenRd}, 32'h44);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R12 empty read byte", {24'd0, seenRd}, 32'hFF);
    check("R12 underrun pulse", {31'd0, seenUnd}, 32'd1);
    check("R12 no mismatch", {31'd0, seenMis}, 32'd0);

    // R7 registers
    hostAccess(0, 0, 1, 3'b011, 8'h3C, 0);
    hostAccess(0, 0, 1, 3'b100, 8'hC3, 0);
    check("R7 ctrl write", {24'd0, ctrlOut}, 32'h3C);
    check("R7 imm write", {24'd0, immOut}, 32'hC3);
    hostAccess(1, 0, 1, 3'b011, 8'h00, 0);
    check("R7 ctrl read", {24'd0, seenRd}, 32'h3C);
    hostAccess(1, 0, 1, 3'b100, 8'h00, 0);
    check("R7 imm read", {24'd0, seenRd}, 32'hC3);

    // R6 status
    hostAccess(1, 0, 1, 3'b010, 8'h00, 0);
    check("R6 status read", {24'd0, seenRd}, 32'hA5);
    hostAccess(0, 0, 1, 3'b010, 8'h77, 0);
    check("R6 ctrl untouched", {24'd0, ctrlOut}, 32'h3C);
    check("R6 imm untouched", {24'd0, immOut}, 32'hC3);
    check("R6 queue untouched", {31'd0, cpuInEmpty}, 32'd1);

    // R8 reserved addresses, R3 deselected sweep
    cpuPushOne(1'b0, 8'h6E);
    for (int a = 5; a < 8; a++) begin
      hostAccess(0, 0, 1, 3'(a), 8'h99, 0);
      hostAccess(1, 0, 1, 3'(a), 8'h00, 0);
      check("R8 rdData kept", {24'd0, seenRd}, 32'hA5);
      check("R8 ctrl kept", {24'd0, ctrlOut}, 32'h3C);
      check("R8 imm kept", {24'd0, immOut}, 32'hC3);
      check("R8 inbound kept", {31'd0, cpuInEmpty}, 32'd1);
    end
    for (int a = 0; a < 8; a++) begin
      hostAccess(0, 0, 0, 3'(a), 8'h5F, 0);
      hostAccess(1, 0, 0, 3'(a), 8'h00, 0);
      check("R3 rdData kept", {24'd0, seenRd}, 32'hA5);
      check("R3 ctrl kept", {24'd0, ctrlOut}, 32'h3C);
      check("R3 imm kept", {24'd0, immOut}, 32'hC3);
      check("R3 inbound kept", {31'd0, cpuInEmpty}, 32'd1);
    end
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R3 R8 outbound kept", {24'd0, seenRd}, 32'h6E);

    // R9 DMA overrides address and select
    hostAccess(0, 1, 0, 3'b011, 8'hD1, 0);
    check("R9 ctrl not written", {24'd0, ctrlOut}, 32'h3C);
    cpuPopCheck("R9 dma write", 1'b0, 8'hD1);
    cpuPushOne(1'b0, 8'hE7);
    hostAccess(1, 1, 1, 3'b010, 8'h00, 0);
    check("R9 dma read", {24'd0, seenRd}, 32'hE7);

    // R2 long strobe acts once
    cpuPushOne(1'b0, 8'h01);
    cpuPushOne(1'b0, 8'h02);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 20);
    check("R2 first read", {24'd0, seenRd}, 32'h01);
    hostAccess(1, 0, 1, 3'b000, 8'h00, 0);
    check("R2 single pop", {24'd0, seenRd}, 32'h02);
    hostAccess(0, 0, 1, 3'b001, 8'h4D, 20);
    cpuPopCheck("R2 single push", 1'b1, 8'h4D);
    @(negedge clk);
    check("R2 one entry only", {31'd0, cpuInEmpty}, 32'd1);

    // R11 overrun
    for (int i = 0; i < 16; i++) hostAccess(0, 0, 1, 3'b000, 8'(i * 7 + 3), 0);
    check("R11 no early overrun", {31'd0, seenOvr}, 32'd0);
    hostAccess(0, 0, 1, 3'b000, 8'hEE, 0);
    check("R11 overrun pulse", {31'd0, seenOvr}, 32'd1);
    for (int i = 0; i < 16; i++) cpuPopCheck("R11 order", 1'b0, 8'(i * 7 + 3));
    @(negedge clk);
    check("R11 dropped byte", {31'd0, cpuInEmpty}, 32'd1);
    for (int i = 0; i < 16; i++) cpuPushOne(1'b1, 8'(i));
    check("R11 outbound full", {31'd0, cpuOutFull}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule